// File: doc/BRIEF.md
# Nibble-Flag Byte Arithmetic Unit

This block is the arithmetic slice of a small accumulator-style processor core. It adds two bytes, adds them with an incoming carry, or steps a single byte up or down by one. Alongside the byte result it produces four condition bits: zero, subtract, half-carry (the carry or borrow across the boundary between the low and high nibble) and carry. Each condition bit comes with its own write enable, so the surrounding core updates only the bits that the operation defines.

The operation is chosen by the instruction byte itself. Register forms take their operand from `opnd_a`, with `opnd_b` as the second addend, and return one registered result. The two memory forms of step-up and step-down run a short sequence on their own. They read the byte that a 16-bit address pair points at, compute on it, and write the new value back to the same address. The unit stays busy for those three cycles and ignores new work until they finish.

Top module: `nib_alu_unit`

## Requirements
- R1: Opcodes 0x80..0x87 add `opnd_a` and `opnd_b`. The result is their sum mod 256. Carry is set when the sum exceeds 0xFF. Half-carry is set when the two low nibbles sum above 0xF. Subtract is 0. `carry_in` is ignored. All four write enables are high.
- R2: Opcodes 0x88..0x8F add `opnd_a`, `opnd_b` and `carry_in`. Carry is set when the total exceeds 0xFF. Half-carry is set when the low nibble of `opnd_a`, plus the low nibble of `opnd_b`, plus `carry_in`, exceeds 0xF. Subtract is 0, and all four enables are high.
- R3: Opcodes 0x04, 0x0C, 0x14, 0x1C, 0x24, 0x2C and 0x3C return `opnd_a`+1 mod 256. Subtract is 0. Half-carry is set when the low nibble of the operand was 0xF. `opnd_b` and `carry_in` are ignored.
- R4: Each opcode of R3 plus one (0x05, 0x0D, 0x15, 0x1D, 0x25, 0x2D, 0x3D) returns `opnd_a`-1 mod 256. Subtract is 1. Half-carry is set when the low nibble of the operand was 0x0.
- R5: The step operations (R3, R4, R7) leave carry alone: `we_c` is 0 and `flag_c` is 0, while `we_z`, `we_n` and `we_h` are 1.
- R6: For a register-form opcode, `res_valid` and the outputs of R1 to R5 appear in the cycle after the one in which `start` is sampled high.
- R7: Opcode 0x34 steps up, and 0x35 steps down, the byte at `pair_addr`. The sequence runs as follows:
  - In the cycle after `start`, `mem_req`=1, `mem_we`=0 and `mem_addr`=`pair_addr`.
  - In the next cycle `mem_req`=0, and `mem_rdata` is taken as the operand.
  - In the cycle after that, `mem_req`=1 and `mem_we`=1 at the same address. `mem_wdata` carries the new byte, and `res_valid` is 1 with its flags.
- R8: `busy` is high during the three memory-form cycles. A `start` sampled while `busy` is high has no effect.
- R9: Any other opcode (for example 0x00 or 0xC3) produces no `res_valid`, no write enable and no memory request.
- R10: Wrap cases follow the same rules:
  - 0xFF stepped up gives 0x00 with zero=1 and half-carry=1.
  - 0x01 stepped down gives 0x00 with zero=1.
  - 0x00 stepped down gives 0xFF with zero=0 and half-carry=1.
- R11: After reset, `res_valid`, `busy`, `mem_req`, `mem_we`, all four write enables and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the operation named by `opcode` |
| opcode | input | 8 | Instruction byte selecting the operation |
| opnd_a | input | DATA_W | First operand, and the only operand of the step operations |
| opnd_b | input | DATA_W | Second addend |
| carry_in | input | 1 | Incoming carry for add-with-carry |
| pair_addr | input | ADDR_W | Address pair for the memory forms |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| result | output | DATA_W | Computed byte |
| res_valid | output | 1 | Result and flags are valid this cycle |
| flag_z | output | 1 | Zero flag value |
| flag_n | output | 1 | Subtract flag value |
| flag_h | output | 1 | Half-carry flag value |
| flag_c | output | 1 | Carry flag value |
| we_z | output | 1 | Write enable for zero |
| we_n | output | 1 | Write enable for subtract |
| we_h | output | 1 | Write enable for half-carry |
| we_c | output | 1 | Write enable for carry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| busy | output | 1 | Memory-form sequence in progress |

## Verification
The bench builds the unit with the default 8-bit data, 4-bit low nibble and 16-bit address. It sets `SPLIT_CHAIN` to 1, so the high half of every sum hangs off the carry out of the low nibble adder. That arrangement lets one table of vectors show whether the nibble carry, including the carry-in contribution, reaches both the half-carry flag and the upper result bits. The memory-form runs use two different address pairs and a start pulse that arrives while the unit is busy. These runs cover the read, gap and write-back cycles and the blocking of new work during them.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

   localparam int OPC_W = 8;

   typedef enum logic [2:0] {
      K_NONE,
      K_ADD,
      K_ADC,
      K_INC,
      K_DEC
   } alu_kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_READ,
      S_CALC,
      S_WRITE
   } seq_state_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flag_set_t;

endpackage

// File: rtl/nib_alu_decode.sv
module nib_alu_decode
   import nib_alu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output alu_kind_e        kind,
   output logic             mem_form
);

   logic step_grp;

   // Step opcodes live in the lowest quarter: column 4 steps up, column 5 steps down.
   assign step_grp = (opcode[7:6] == 2'b00) && (opcode[2:1] == 2'b10);

   always_comb begin
      kind = K_NONE;
      if (step_grp) begin
         kind = opcode[0] ? K_DEC : K_INC;
      end else if (opcode[7:3] == 5'b10000) begin
         kind = K_ADD;
      end else if (opcode[7:3] == 5'b10001) begin
         kind = K_ADC;
      end
   end

   // Row 6 of the step group addresses memory through the pair.
   assign mem_form = step_grp && (opcode[5:3] == 3'b110);

endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
   import nib_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_W      = 4,
   parameter bit SPLIT_CHAIN = 1'b0
) (
   input  alu_kind_e         kind,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output flag_set_t         flags,
   output flag_set_t         wr_en
);

   localparam int HI_W = DATA_W - HALF_W;

   if (HALF_W < 1 || HALF_W >= DATA_W) begin : g_bad_split
      $error("nib_alu_core: HALF_W must lie between 1 and DATA_W-1");
   end

   logic [DATA_W-1:0] b_eff;
   logic              cin_eff;
   logic [HALF_W:0]   lo_sum;
   logic              cout;
   logic              arith;

   always_comb begin
      unique case (kind)
         K_INC:   b_eff = DATA_W'(1);
         K_DEC:   b_eff = '1;
         default: b_eff = b;
      endcase
   end

   assign cin_eff = (kind == K_ADC) && cin;
   assign arith   = (kind == K_ADD) || (kind == K_ADC);

   assign lo_sum = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin_eff};

   if (SPLIT_CHAIN) begin : g_chain
      logic [HI_W:0] hi_sum;
      assign hi_sum = {1'b0, a[DATA_W-1:HALF_W]} + {1'b0, b_eff[DATA_W-1:HALF_W]}
                    + {{HI_W{1'b0}}, lo_sum[HALF_W]};
      assign res  = {hi_sum[HI_W-1:0], lo_sum[HALF_W-1:0]};
      assign cout = hi_sum[HI_W];
   end else begin : g_wide
      logic [DATA_W:0] full;
      assign full = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
      assign res  = full[DATA_W-1:0];
      assign cout = full[DATA_W];
   end

   // Stepping down adds all ones: no nibble carry means a borrow out of the low nibble.
   always_comb begin
      flags.z = (res == '0);
      flags.n = (kind == K_DEC);
      flags.h = (kind == K_DEC) ? ~lo_sum[HALF_W] : lo_sum[HALF_W];
      flags.c = arith && cout;
      wr_en.z = (kind != K_NONE);
      wr_en.n = (kind != K_NONE);
      wr_en.h = (kind != K_NONE);
      wr_en.c = arith;
   end

endmodule

// File: rtl/nib_alu_seq.sv
module nib_alu_seq
   import nib_alu_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  alu_kind_e         kind_in,
   input  logic [ADDR_W-1:0] addr_in,
   output seq_state_e        state,
   output alu_kind_e         kind_q,
   output logic [ADDR_W-1:0] addr_q
);

   seq_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         S_IDLE:  if (launch) state_nx = S_READ;
         S_READ:  state_nx = S_CALC;
         S_CALC:  state_nx = S_WRITE;
         S_WRITE: state_nx = S_IDLE;
         default: state_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         kind_q <= K_NONE;
         addr_q <= '0;
      end else begin
         state <= state_nx;
         if (state == S_IDLE && launch) begin
            kind_q <= kind_in;
            addr_q <= addr_in;
         end
      end
   end

   // R8: a running sequence holds its captured address until it returns to idle
   p_addr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && state != S_WRITE) |=> $stable(addr_q));

endmodule

// File: rtl/nib_alu_unit.sv
module nib_alu_unit
   import nib_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_W      = 4,
   parameter int ADDR_W      = 16,
   parameter bit SPLIT_CHAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              carry_in,
   input  logic [ADDR_W-1:0] pair_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] result,
   output logic              res_valid,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_h,
   output logic              flag_c,
   output logic              we_z,
   output logic              we_n,
   output logic              we_h,
   output logic              we_c,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("nib_alu_unit: ADDR_W must be positive");
   end

   alu_kind_e         dec_kind;
   logic              dec_mem;
   seq_state_e        state;
   alu_kind_e         kind_q;
   logic [ADDR_W-1:0] addr_q;
   alu_kind_e         alu_kind;
   logic [DATA_W-1:0] alu_a;
   logic [DATA_W-1:0] alu_res;
   flag_set_t         alu_flags;
   flag_set_t         alu_en;
   logic              load_reg;
   logic              load_mem;
   logic              launch;
   logic [DATA_W-1:0] result_q;
   flag_set_t         flags_q;
   flag_set_t         en_q;
   logic              valid_q;

   nib_alu_decode u_decode (
      .opcode   (opcode),
      .kind     (dec_kind),
      .mem_form (dec_mem)
   );

   assign busy     = (state != S_IDLE);
   assign load_reg = start && !busy && (dec_kind != K_NONE) && !dec_mem;
   assign launch   = start && !busy && dec_mem;
   assign load_mem = (state == S_CALC);

   nib_alu_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .kind_in (dec_kind),
      .addr_in (pair_addr),
      .state   (state),
      .kind_q  (kind_q),
      .addr_q  (addr_q)
   );

   assign alu_kind = load_mem ? kind_q : dec_kind;
   assign alu_a    = load_mem ? mem_rdata : opnd_a;

   nib_alu_core #(
      .DATA_W      (DATA_W),
      .HALF_W      (HALF_W),
      .SPLIT_CHAIN (SPLIT_CHAIN)
   ) u_core (
      .kind  (alu_kind),
      .a     (alu_a),
      .b     (opnd_b),
      .cin   (carry_in),
      .res   (alu_res),
      .flags (alu_flags),
      .wr_en (alu_en)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         flags_q  <= '0;
         en_q     <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= load_reg || load_mem;
         if (load_reg || load_mem) begin
            result_q <= alu_res;
            flags_q  <= alu_flags;
            en_q     <= alu_en;
         end else begin
            en_q <= '0;
         end
      end
   end

   assign result    = result_q;
   assign res_valid = valid_q;
   assign flag_z    = flags_q.z;
   assign flag_n    = flags_q.n;
   assign flag_h    = flags_q.h;
   assign flag_c    = flags_q.c;
   assign we_z      = en_q.z;
   assign we_n      = en_q.n;
   assign we_h      = en_q.h;
   assign we_c      = en_q.c;
   assign mem_req   = (state == S_READ) || (state == S_WRITE);
   assign mem_we    = (state == S_WRITE);
   assign mem_addr  = addr_q;
   assign mem_wdata = result_q;

   // R7: a read is followed by one idle cycle, then the write-back
   p_read_gap_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> !mem_req ##1 (mem_req && mem_we));

   // R7: the write-back goes to the address that was read
   p_write_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr == $past(mem_addr, 2)));

   // R7: the written byte is the reported result
   p_write_is_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (res_valid && mem_wdata == result));

   // R5: an update without carry write is a step operation: three enables, carry low
   p_step_keeps_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !we_c) |-> (!flag_c && we_z && we_n && we_h));

   // R1: add operations never report subtract
   p_add_clears_n_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && we_c) |-> (!flag_n && we_z && we_h));

   // R10: zero flag agrees with the reported byte
   p_zero_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (flag_z == (result == '0)));

   // R9: no memory traffic outside a sequence
   p_idle_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

endmodule

// File: tb/nib_alu_unit_bench.sv
module nib_alu_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 18;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [7:0]  opcode;
   logic [7:0]  opnd_a;
   logic [7:0]  opnd_b;
   logic        carry_in;
   logic [15:0] pair_addr;
   logic [7:0]  mem_rdata;
   logic [7:0]  result;
   logic        res_valid;
   logic        flag_z, flag_n, flag_h, flag_c;
   logic        we_z, we_n, we_h, we_c;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        busy;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [15:0] wr_addr_seen;
   logic [7:0]  wr_data_seen;

   always #(CLK_PERIOD / 2) clk = ~clk;

   nib_alu_unit #(
      .DATA_W      (8),
      .HALF_W      (4),
      .ADDR_W      (16),
      .SPLIT_CHAIN (1'b1)
   ) u_nib_alu_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .opcode    (opcode),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .carry_in  (carry_in),
      .pair_addr (pair_addr),
      .mem_rdata (mem_rdata),
      .result    (result),
      .res_valid (res_valid),
      .flag_z    (flag_z),
      .flag_n    (flag_n),
      .flag_h    (flag_h),
      .flag_c    (flag_c),
      .we_z      (we_z),
      .we_n      (we_n),
      .we_h      (we_h),
      .we_c      (we_c),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .busy      (busy)
   );

   // Memory model: registered read of a fixed pattern, writes recorded.
   always @(posedge clk) begin
      if (mem_req && !mem_we) begin
         case (mem_addr[7:0])
            8'h34:   mem_rdata <= 8'hFF;
            8'h80:   mem_rdata <= 8'h10;
            default: mem_rdata <= 8'h00;
         endcase
      end
      if (mem_req && mem_we) begin
         wr_addr_seen <= mem_addr;
         wr_data_seen <= mem_wdata;
      end
   end

   // {req, opcode, a, b, cin, result, flags zNHC, enables zNHC}
   localparam logic [44:0] VEC [NVEC] = '{
      {4'd1,  8'h80, 8'h3A, 8'hC6, 1'b0, 8'h00, 4'b1011, 4'b1111}, // R1 carry and nibble carry
      {4'd1,  8'h81, 8'h12, 8'h34, 1'b0, 8'h46, 4'b0000, 4'b1111}, // R1 plain
      {4'd1,  8'h80, 8'h0F, 8'h01, 1'b0, 8'h10, 4'b0010, 4'b1111}, // R1 nibble only
      {4'd2,  8'h88, 8'h0F, 8'h00, 1'b1, 8'h10, 4'b0010, 4'b1111}, // R2 carry-in crosses nibble
      {4'd2,  8'h89, 8'hFF, 8'h00, 1'b1, 8'h00, 4'b1011, 4'b1111}, // R2 carry-in overflows
      {4'd2,  8'h8A, 8'h80, 8'h7F, 1'b1, 8'h00, 4'b1011, 4'b1111}, // R2 second addition overflows
      {4'd2,  8'h8B, 8'h20, 8'h30, 1'b0, 8'h50, 4'b0000, 4'b1111}, // R2 no carry-in
      {4'd2,  8'h8C, 8'h7E, 8'h80, 1'b1, 8'hFF, 4'b0000, 4'b1111}, // R2 nibble reaches F only
      {4'd10, 8'h04, 8'hFF, 8'h00, 1'b0, 8'h00, 4'b1010, 4'b1110}, // R10 wrap up
      {4'd3,  8'h3C, 8'h0F, 8'h00, 1'b0, 8'h10, 4'b0010, 4'b1110}, // R3 nibble carry
      {4'd3,  8'h2C, 8'h41, 8'h00, 1'b0, 8'h42, 4'b0000, 4'b1110}, // R3 plain
      {4'd10, 8'h0D, 8'h01, 8'h00, 1'b0, 8'h00, 4'b1100, 4'b1110}, // R10 down to zero
      {4'd10, 8'h3D, 8'h00, 8'h00, 1'b0, 8'hFF, 4'b0110, 4'b1110}, // R10 wrap down
      {4'd4,  8'h1D, 8'h10, 8'h00, 1'b0, 8'h0F, 4'b0110, 4'b1110}, // R4 nibble borrow
      {4'd4,  8'h25, 8'h88, 8'h00, 1'b0, 8'h87, 4'b0100, 4'b1110}, // R4 plain
      {4'd3,  8'h14, 8'h7F, 8'h00, 1'b0, 8'h80, 4'b0010, 4'b1110}, // R3 into sign bit
      {4'd1,  8'h82, 8'h01, 8'h01, 1'b1, 8'h02, 4'b0000, 4'b1111}, // R1 carry-in ignored
      {4'd5,  8'h1C, 8'h05, 8'hFF, 1'b1, 8'h06, 4'b0000, 4'b1110}  // R5 b and carry-in ignored
   };

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic ci);
      @(negedge clk);
      start    = 1'b1;
      opcode   = op;
      opnd_a   = a;
      opnd_b   = b;
      carry_in = ci;
      @(negedge clk);
      start = 1'b0;
   endtask

   function automatic logic [9:0] outs();
      return {res_valid, flag_z, flag_n, flag_h, flag_c, we_z, we_n, we_h, we_c, mem_req};
   endfunction

   task automatic mem_run(input string tag, input logic [7:0] op, input logic [15:0] addr,
                          input logic [7:0] exp_res, input logic [3:0] exp_flg);
      @(negedge clk);
      start     = 1'b1;
      opcode    = op;
      pair_addr = addr;
      @(negedge clk);
      // R7 read cycle
      check({tag, " R7 read request"}, {busy, mem_req, mem_we, res_valid, mem_addr},
            {1'b1, 1'b1, 1'b0, 1'b0, addr});
      // R8 attempt to launch a step-up while busy
      start    = 1'b1;
      opcode   = 8'h3C;
      opnd_a   = 8'h00;
      pair_addr = 16'h0000;
      @(negedge clk);
      check({tag, " R8 start ignored while busy"}, {busy, mem_req, res_valid},
            {1'b1, 1'b0, 1'b0});
      start = 1'b0;
      @(negedge clk);
      // R7 write-back cycle with R5 enables
      check({tag, " R7 write-back"}, {mem_req, mem_we, mem_addr, mem_wdata},
            {1'b1, 1'b1, addr, exp_res});
      check({tag, " R7 R5 result and flags"}, {result, outs()},
            {exp_res, 1'b1, exp_flg, 4'b1110, 1'b1});
      @(negedge clk);
      check({tag, " R8 returns idle"}, {busy, mem_req, res_valid, wr_addr_seen, wr_data_seen},
            {1'b0, 1'b0, 1'b0, addr, exp_res});
   endtask

   initial begin
      rst_n     = 1'b0;
      start     = 1'b0;
      opcode    = 8'h00;
      opnd_a    = 8'h00;
      opnd_b    = 8'h00;
      carry_in  = 1'b0;
      pair_addr = 16'h0000;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 reset outputs", {result, res_valid, busy, mem_req, mem_we, we_z, we_n, we_h, we_c},
            '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [44:0] v;
         v = VEC[i];
         issue(v[40:33], v[32:25], v[24:17], v[16]);
         // R6 valid the cycle after start, with the expected byte and flags
         check($sformatf("R%0d R6 vector %0d op %h", v[44:41], i, v[40:33]),
               {result, outs()}, {v[15:8], 1'b1, v[7:4], v[3:0], 1'b0});
      end

      // R6 valid is a single-cycle pulse
      @(negedge clk);
      check("R6 valid drops after one cycle", {res_valid, we_z, we_c}, 3'b000);

      // R9 unsupported opcodes
      issue(8'h00, 8'h55, 8'h55, 1'b1);
      check("R9 opcode 00 ignored", {res_valid, we_z, we_n, we_h, we_c, mem_req, busy}, '0);
      issue(8'hC3, 8'hFF, 8'h01, 1'b0);
      check("R9 opcode C3 ignored", {res_valid, we_z, we_n, we_h, we_c, mem_req, busy}, '0);

      // R7 memory forms
      mem_run("mem step up", 8'h34, 16'h1234, 8'h00, 4'b1010);
      mem_run("mem step down", 8'h35, 16'hFF80, 8'h0F, 4'b0110);

      // R8 work accepted again right after a sequence
      issue(8'h3C, 8'h0F, 8'h00, 1'b0);
      check("R8 accepts work after sequence", {result, outs()},
            {8'h10, 1'b1, 4'b0010, 4'b1110, 1'b0});

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule